// File: doc/BRIEF.md
# Tiled Fraction Multiplier

This combinational block forms the product of the fraction fields of two floating-point operands. Each operand carries a sign bit above a 24-bit fraction. Each magnitude is zero-extended to a whole number of `DIGIT_W`-bit digits. Every pair of digits, one from each operand, is multiplied by a small digit multiplier. Each digit product is shifted to its weight, which is `DIGIT_W * (i + j)` bits for digit i of A and digit j of B, and becomes one summand.

The summands pass through successive rows of (p,2) column counters until only two rows remain. A counter with p inputs is built as a chain of carry-save stages, and its carries move one column up without rippling. A final carry-propagate adder sums the two rows into the 48-bit magnitude.

A mode input chooses how operands and the result are read:
- **Sign-magnitude mode:** the product is returned as sign over magnitude.
- **Two's-complement mode:** each operand is a 25-bit two's-complement value. It is converted to a magnitude at the input, and the result is negated when the product sign is set.

Exponent handling, normalization and rounding belong to neighbouring blocks.

Top module: `fm_frac_mul`

## Requirements
- R1: With `modeTwos`=0, `prodMag` equals `opA[23:0]` × `opB[23:0]` as an unsigned 48-bit value.
- R2: `prodSign` equals `opA[24]` XOR `opB[24]` in both modes.
- R3: With `modeTwos`=0, `prodOut` is `{prodSign, prodMag}`: the sign is bit 48 and the magnitude is bits 47:0.
- R4: With `modeTwos`=1, `prodMag` is the absolute value of the product of the two 25-bit two's-complement operands.
- R5: With `modeTwos`=1, `prodOut` is the 49-bit two's-complement product of the operands.
- R6: `DIGIT_W` may be 9, 13, 17 or 21, and every one of these gives the same results for the same inputs.
- R7: `CTR_P` may be 3, 5 or 7, and every one of these gives the same results for the same inputs. The reduction always ends in exactly two rows whose sum equals the sum of all summands.
- R8: A zero magnitude on either operand gives `prodMag` = 0.
- R9: The largest fraction times itself, (2^24−1)², is returned exactly as 0xFFFFFE000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| modeTwos | input | 1 | 1: operands and `prodOut` are two's complement; 0: sign-magnitude |
| opA | input | 25 | Operand A: the sign is bit 24 and the fraction is bits 23:0 |
| opB | input | 25 | Operand B, in the same layout as A |
| prodSign | output | 1 | Sign of the product |
| prodMag | output | 48 | Magnitude of the product |
| prodOut | output | 49 | The product in the format chosen by `modeTwos` |

## Verification
The checks take one thing for granted about the inputs. In two's-complement mode, no operand is the most negative code (bit 24 set, fraction zero), because its magnitude does not fit in 24 bits. The datapath flags that code. The stimulus drops the code from the corner list when in two's-complement mode and replaces it whenever the pseudo-random generator produces it. Every other corner, including zero, all ones and the largest fraction, is swept in both modes. These sweeps run on four instances that cover all digit widths and counter sizes.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic negA;     // operand A must be negated to get its magnitude
    logic negB;     // operand B must be negated to get its magnitude
    logic negOut;   // product sign
    logic twosOut;  // emit a two's-complement result
  } fm_ctrl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
(
  input  logic     modeTwos,
  input  logic     signA,
  input  logic     signB,
  output fm_ctrl_t ctrl
);

  always_comb begin
    ctrl.negA    = modeTwos & signA;
    ctrl.negB    = modeTwos & signB;
    ctrl.negOut  = signA ^ signB;
    ctrl.twosOut = modeTwos;
  end

endmodule

// File: rtl/fm_tiles.sv
module fm_tiles
  import fm_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int DIGIT_W = 9,
  localparam int NUM_DIG = ceilDiv(FRAC_W, DIGIT_W),
  localparam int EXT_W   = NUM_DIG * DIGIT_W,
  localparam int PW      = 2 * FRAC_W,
  localparam int NSUM    = NUM_DIG * NUM_DIG
) (
  input  logic [FRAC_W-1:0]        magA,
  input  logic [FRAC_W-1:0]        magB,
  output logic [NSUM-1:0][PW-1:0]  summands
);

  logic [EXT_W-1:0] extA;
  logic [EXT_W-1:0] extB;

  assign extA = EXT_W'(magA);
  assign extB = EXT_W'(magB);

  for (genvar gi = 0; gi < NUM_DIG; gi++) begin : g_rowA
    for (genvar gj = 0; gj < NUM_DIG; gj++) begin : g_colB
      localparam int SHIFT = DIGIT_W * (gi + gj);
      logic [2*DIGIT_W-1:0] digitProd;

      // One small digit multiplier per digit pair.
      assign digitProd = extA[gi*DIGIT_W +: DIGIT_W] * extB[gj*DIGIT_W +: DIGIT_W];

      // Place the digit product at its weight; anything above PW would be zero.
      assign summands[gi*NUM_DIG + gj] = PW'(digitProd) << SHIFT;
    end
  end

endmodule

// File: rtl/fm_reduce.sv
module fm_reduce #(
  parameter int PW    = 48,
  parameter int NSUM  = 9,
  parameter int CTR_P = 3
) (
  input  logic [NSUM-1:0][PW-1:0] summands,
  output logic [PW-1:0]           rowSum,
  output logic [PW-1:0]           rowCarry
);

  // Each level removes at least one row, so NSUM levels always suffice.
  localparam int MAX_LVL = NSUM;

  always_comb begin
    logic [NSUM-1:0][PW-1:0] work;
    logic [NSUM-1:0][PW-1:0] nxt;
    logic [PW-1:0] accS;
    logic [PW-1:0] accC;
    logic [PW-1:0] addend;
    logic [PW-1:0] newS;
    logic [PW-1:0] refSum;
    int rows;
    int grp;
    int numGrp;
    int leftOver;

    work = summands;
    rows = NSUM;

    for (int lvl = 0; lvl < MAX_LVL; lvl++) begin
      if (rows > 2) begin
        // Inputs per counter on this level, capped by the rows still present.
        grp      = (CTR_P < rows) ? CTR_P : rows;
        numGrp   = rows / grp;
        leftOver = rows - numGrp * grp;
        nxt      = '0;

        for (int g = 0; g < NSUM; g++) begin
          if (g < numGrp) begin
            // A (p,2) counter: a chain of carry-save stages whose carries
            // move one column up and never ripple.
            accS = work[g*grp];
            accC = work[g*grp + 1];
            for (int k = 2; k < CTR_P; k++) begin
              if (k < grp) begin
                addend = work[g*grp + k];
                newS   = accS ^ accC ^ addend;
                accC   = ((accS & accC) | (accS & addend) | (accC & addend)) << 1;
                accS   = newS;
              end
            end
            nxt[2*g]     = accS;
            nxt[2*g + 1] = accC;
          end
        end

        // Rows that do not fill a whole counter pass straight to the next level.
        for (int r = 0; r < CTR_P; r++) begin
          if (r < leftOver) begin
            nxt[2*numGrp + r] = work[numGrp*grp + r];
          end
        end

        work = nxt;
        rows = 2 * numGrp + leftOver;
      end
    end

    rowSum   = work[0];
    rowCarry = work[1];

    refSum = '0;
    for (int k = 0; k < NSUM; k++) begin
      refSum = refSum + summands[k];
    end

    // R7: the reduction ends in exactly two rows.
    a_r7_two_rows: assert (rows == 2)
      else $error("reduction left %0d rows", rows);

    // R7: the rows that remain keep the total of the summands.
    a_r7_rows_keep_total: assert (rowSum + rowCarry == refSum)
      else $error("row total differs from summand total");
  end

endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int DIGIT_W = 9,
  parameter int CTR_P   = 3,
  localparam int NUM_DIG = ceilDiv(FRAC_W, DIGIT_W),
  localparam int NSUM    = NUM_DIG * NUM_DIG,
  localparam int PW      = 2 * FRAC_W
) (
  input  fm_ctrl_t          ctrl,
  input  logic [FRAC_W-1:0] fracA,
  input  logic [FRAC_W-1:0] fracB,
  output logic [PW-1:0]     prodMag,
  output logic [PW:0]       prodOut
);

  logic [FRAC_W-1:0]       magA;
  logic [FRAC_W-1:0]       magB;
  logic [NSUM-1:0][PW-1:0] summands;
  logic [PW-1:0]           rowSum;
  logic [PW-1:0]           rowCarry;
  logic [PW:0]             widened;
  logic [PW:0]             negated;

  // Magnitude of a negative two's-complement operand: 2^FRAC_W minus its fraction.
  assign magA = ctrl.negA ? (~fracA + 1'b1) : fracA;
  assign magB = ctrl.negB ? (~fracB + 1'b1) : fracB;

  fm_tiles #(
    .FRAC_W  (FRAC_W),
    .DIGIT_W (DIGIT_W)
  ) u_tiles (
    .magA     (magA),
    .magB     (magB),
    .summands (summands)
  );

  fm_reduce #(
    .PW    (PW),
    .NSUM  (NSUM),
    .CTR_P (CTR_P)
  ) u_reduce (
    .summands (summands),
    .rowSum   (rowSum),
    .rowCarry (rowCarry)
  );

  // Final carry-propagate adder.
  assign prodMag = rowSum + rowCarry;

  assign widened = {1'b0, prodMag};
  assign negated = ~widened + 1'b1;

  always_comb begin
    if (ctrl.twosOut) begin
      prodOut = ctrl.negOut ? negated : widened;
    end else begin
      prodOut = {ctrl.negOut, prodMag};
    end
  end

  always_comb begin
    // R4: in two's-complement mode the most negative code is outside the operand range.
    a_r4_no_min_neg: assert (!((ctrl.negA && fracA == '0) || (ctrl.negB && fracB == '0)))
      else $error("most negative two's-complement operand applied");

    // R8: a zero magnitude on either side gives a zero product.
    a_r8_zero_operand: assert (!(magA == '0 || magB == '0) || prodMag == '0)
      else $error("zero operand gave a nonzero product");

    // R5: a nonzero two's-complement result carries the product sign on top.
    a_r5_sign_on_top: assert (!(ctrl.twosOut && prodMag != '0) || prodOut[PW] == ctrl.negOut)
      else $error("two's-complement result has the wrong sign");
  end

endmodule

// File: rtl/fm_frac_mul.sv
module fm_frac_mul
  import fm_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int DIGIT_W = 9,
  parameter int CTR_P   = 3,
  localparam int PW = 2 * FRAC_W
) (
  input  logic            modeTwos,
  input  logic [FRAC_W:0] opA,
  input  logic [FRAC_W:0] opB,
  output logic            prodSign,
  output logic [PW-1:0]   prodMag,
  output logic [PW:0]     prodOut
);

  if (!(DIGIT_W == 9 || DIGIT_W == 13 || DIGIT_W == 17 || DIGIT_W == 21) ||
      !(CTR_P == 3 || CTR_P == 5 || CTR_P == 7)) begin : g_badParam
    $error("unsupported digit width or counter size");
  end

  fm_ctrl_t ctrl;

  fm_ctrl u_ctrl (
    .modeTwos (modeTwos),
    .signA    (opA[FRAC_W]),
    .signB    (opB[FRAC_W]),
    .ctrl     (ctrl)
  );

  fm_datapath #(
    .FRAC_W  (FRAC_W),
    .DIGIT_W (DIGIT_W),
    .CTR_P   (CTR_P)
  ) u_datapath (
    .ctrl    (ctrl),
    .fracA   (opA[FRAC_W-1:0]),
    .fracB   (opB[FRAC_W-1:0]),
    .prodMag (prodMag),
    .prodOut (prodOut)
  );

  assign prodSign = ctrl.negOut;

endmodule

// File: tb/test_fm_frac_mul.sv
module test_fm_frac_mul;

  localparam int NI = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        modeTwos = 1'b0;
  logic [24:0] opA = '0;
  logic [24:0] opB = '0;

  logic        sgn [NI];
  logic [47:0] mag [NI];
  logic [48:0] pout[NI];

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  fm_frac_mul #(.DIGIT_W(9),  .CTR_P(3)) i_fm_frac_mul (
    .modeTwos(modeTwos), .opA(opA), .opB(opB),
    .prodSign(sgn[0]), .prodMag(mag[0]), .prodOut(pout[0]));
  fm_frac_mul #(.DIGIT_W(13), .CTR_P(5)) i_fm_frac_mul_w13 (
    .modeTwos(modeTwos), .opA(opA), .opB(opB),
    .prodSign(sgn[1]), .prodMag(mag[1]), .prodOut(pout[1]));
  fm_frac_mul #(.DIGIT_W(17), .CTR_P(7)) i_fm_frac_mul_w17 (
    .modeTwos(modeTwos), .opA(opA), .opB(opB),
    .prodSign(sgn[2]), .prodMag(mag[2]), .prodOut(pout[2]));
  fm_frac_mul #(.DIGIT_W(21), .CTR_P(3)) i_fm_frac_mul_w21 (
    .modeTwos(modeTwos), .opA(opA), .opB(opB),
    .prodSign(sgn[3]), .prodMag(mag[3]), .prodOut(pout[3]));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h (mode %0d A %h B %h)",
               tag, got, exp, modeTwos, opA, opB);
    end
  endtask

  task automatic runVec(input bit mode, input logic [24:0] a, input logic [24:0] b);
    longint sa, sb, sp, ma, mb;
    logic [47:0] expMag;
    logic [48:0] expOut;
    logic        expSign;
    string       magTag;
    modeTwos = mode;
    opA = a;
    opB = b;
    @(negedge clk);
    expSign = a[24] ^ b[24];
    if (mode) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sp = sa * sb;
      expOut = sp[48:0];
      expMag = (sp < 0) ? 48'(-sp) : 48'(sp);
      ma = (sa < 0) ? -sa : sa;
      mb = (sb < 0) ? -sb : sb;
    end else begin
      ma = longint'(a[23:0]);
      mb = longint'(b[23:0]);
      sp = ma * mb;
      expMag = sp[47:0];
      expOut = {expSign, expMag};
    end
    if (ma == 0 || mb == 0) magTag = "R8";
    else if (ma == 64'hFFFFFF && mb == 64'hFFFFFF) magTag = "R9";
    else if (mode) magTag = "R4";
    else magTag = "R1";
    chk(magTag, 64'(mag[0]), 64'(expMag));
    chk("R2", 64'(sgn[0]), 64'(expSign));
    chk(mode ? "R5" : "R3", 64'(pout[0]), 64'(expOut));
    for (int k = 1; k < NI; k++) begin
      chk("R6", 64'(mag[k]), 64'(expMag));
      chk("R7", 64'(pout[k]), 64'(expOut));
      chk("R2", 64'(sgn[k]), 64'(expSign));
    end
  endtask

  logic [24:0] corner [7];
  initial begin
    corner[0] = 25'h0000000;
    corner[1] = 25'h0000001;
    corner[2] = 25'h0FFFFFF;
    corner[3] = 25'h1FFFFFF;
    corner[4] = 25'h1000001;
    corner[5] = 25'h0800000;
    corner[6] = 25'h1000000;
  end

  initial begin
    logic [31:0] lfsr;
    logic [24:0] ra, rb;
    @(negedge clk);
    // Idle inputs (all zero): zero product, positive sign.
    chk("R8", 64'(mag[0]), 64'd0);
    chk("R3", 64'(pout[0]), 64'd0);
    // Largest fraction squared, stated value.
    runVec(1'b0, 25'h0FFFFFF, 25'h0FFFFFF);
    chk("R9", 64'(mag[0]), 64'hFFFFFE000001);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 7; j++) begin
          if (!(m == 1 && (i == 6 || j == 6))) begin
            runVec(bit'(m), corner[i], corner[j]);
          end
        end
      end
    end
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr[24:0];
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      rb = lfsr[31:7];
      if (n[0]) begin
        if (ra == 25'h1000000) ra = 25'h1000003;
        if (rb == 25'h1000000) rb = 25'h1000005;
      end
      runVec(n[0], ra, rb);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
    end
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule